// File: doc/BRIEF.md
# SPI Serial Memory Command Front End

This block is the slave side of a four-wire serial link to a byte-wide memory. It sits on the chip clock and oversamples the serial pins. The link pins are chip select (active low), serial clock, serial data in, a pause input (active low) and serial data out with its own output enable. Each transfer opens with an 8-bit opcode. An address and data bytes follow when the opcode calls for them. Every field moves most significant bit first. Read data and the status byte leave on the output pin. Write data is collected in a one-page staging buffer.

A separate permission and status unit decides whether a finished write may proceed. It holds the write-enable flag, the two block-protect bits and the busy flag. When a write is granted, it runs a timed write cycle, and during that cycle the staged page is copied into the array. The array is an internal register array of `2**ADDR_W` bytes. The default is kept small; setting `ADDR_W` to 14 gives a 16K x 8 array. Address bits above the array size are ignored.

Top module: `smf_spi_mem_front`

## Requirements
- R1: Only opcodes 0x06 (set write enable), 0x04 (clear write enable), 0x05 (read status), 0x01 (write status), 0x03 (read) and 0x02 (write) are acted on. Any other opcode leaves all state unchanged and keeps `spi_so_en` low for the rest of that select period.
- R2: Input bits are taken on rising serial clock edges while chip select is low, counting from the first such edge after chip select falls. Output bits change only after a falling serial clock edge. All fields are most significant bit first, and the address is two bytes sent high byte first.
- R3: Opcode 0x06 sets the write-enable flag (status bit 1) and 0x04 clears it, as soon as the eighth opcode bit is taken.
- R4: Read status streams the byte {0000, protect[1:0], write-enable, busy}, with busy as bit 0, repeated for as long as clocks continue. While a write cycle is in progress it reads 0xFF.
- R5: Read returns the byte at the given address and then successive bytes for as long as clocks continue. The address counter wraps from the top of the array back to 0.
- R6: Write data bytes land at successive addresses that wrap within the 32-byte page of the start address.
- R7: A write or status write starts a write cycle only if chip select rises with zero bits pending in the current byte, at least one complete data byte has been sent, and the write-enable flag is set. Otherwise nothing is stored and the write-enable flag is unchanged.
- R8: A write cycle keeps busy set for `WR_CYCLES` clocks. While busy, every opcode except read status is ignored. At the end of the cycle busy and write-enable both clear.
- R9: While the pause input is low, serial clock edges are ignored and `spi_so_en` is low. When the pause is released, the transfer continues from the same bit.
- R10: Protect value 01 blocks writes to the top quarter of the array, 10 blocks the top half and 11 blocks all of it. A blocked write starts no cycle and leaves write-enable set.
- R11: Status write stores bits 3:2 of its last data byte as the protect value, under the commit rule of R7.
- R12: After reset the status byte reads 0x00 and `spi_so_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock; serial pins are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause input, active low |
| spi_so | output | 1 | Serial data out |
| spi_so_en | output | 1 | Output enable for `spi_so` (low means high impedance) |

## Verification
The bench ends a write three bits into a byte and also with no data byte at all. A design that commits on any chip-select rise would set busy and overwrite stored data. It starts a page write two bytes before the end of a page, and reads one byte before the top of the array, so a carry into the page number or a missing address wrap shows up as wrong read-back data. It pauses a read mid-byte and keeps toggling the clock during the pause, so a design that counts those edges returns a shifted byte. It also issues set-write-enable during a busy cycle and writes into protected quarters; if either is obeyed, the status byte or the read-back differs from the expected value.

// File: rtl/smf_pkg.sv
package smf_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OPC_WEN   = 8'h06;
  localparam logic [BYTE_W-1:0] OPC_WDIS  = 8'h04;
  localparam logic [BYTE_W-1:0] OPC_RSTAT = 8'h05;
  localparam logic [BYTE_W-1:0] OPC_WSTAT = 8'h01;
  localparam logic [BYTE_W-1:0] OPC_RD    = 8'h03;
  localparam logic [BYTE_W-1:0] OPC_WR    = 8'h02;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADR, PH_RDAT, PH_STAT, PH_WDAT, PH_SDAT, PH_SKIP
  } phase_e;

  typedef enum logic {TGT_ARRAY, TGT_STATUS} tgt_e;
endpackage

// File: rtl/smf_bit_engine.sv
module smf_bit_engine import smf_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              fall_stb,
  output logic              cs_rise,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_val,
  output logic [2:0]        bit_cnt
);
  logic              sck_q, cs_q, live, rise_stb;
  logic [BYTE_W-2:0] sh_q, sh_d;
  logic [2:0]        cnt_d;

  assign live     = !cs_n && hold_n;
  assign rise_stb = live && sck && !sck_q;
  assign fall_stb = live && !sck && sck_q;
  assign cs_rise  = cs_n && !cs_q;
  assign byte_stb = rise_stb && (bit_cnt == 3'd7);
  assign byte_val = {sh_q, si};

  always_comb begin
    sh_d  = sh_q;
    cnt_d = bit_cnt;
    if (cs_n) begin
      cnt_d = 3'd0;
    end else if (rise_stb) begin
      sh_d  = {sh_q[BYTE_W-3:0], si};
      cnt_d = bit_cnt + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      sh_q    <= '0;
      bit_cnt <= 3'd0;
    end else begin
      sck_q   <= sck;
      cs_q    <= cs_n;
      sh_q    <= sh_d;
      bit_cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/smf_cmd_seq.sv
module smf_cmd_seq import smf_pkg::*; #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              fall_stb,
  input  logic              cs_rise,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic [2:0]        bit_cnt,
  input  logic              wip,
  input  logic [BYTE_W-1:0] status_byte,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              so,
  output logic              so_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              set_wel,
  output logic              clr_wel,
  output logic              buf_clr,
  output logic              buf_we,
  output logic [PAGE_W-1:0] buf_idx,
  output logic [BYTE_W-1:0] buf_data,
  output logic              commit_req,
  output tgt_e              commit_tgt,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [1:0]        commit_sr
);
  localparam int FULL_W = 2 * BYTE_W;

  phase_e              phase_q, phase_d;
  logic                is_wr_q, is_wr_d, adr_cnt_q, adr_cnt_d, got_q, got_d, so_q, so_d;
  logic [BYTE_W-1:0]   adr_hi_q, adr_hi_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [PAGE_W-1:0]   off_q, off_d;
  logic [1:0]          sr_q, sr_d;
  logic [FULL_W-1:0]   full_addr;

  assign full_addr = {adr_hi_q, byte_val};

  generate
    if (ADDR_W < FULL_W) begin : g_hi_sink
      logic unused_addr_hi;
      assign unused_addr_hi = ^full_addr[FULL_W-1:ADDR_W];
    end
  endgenerate

  always_comb begin
    phase_d = phase_q;  is_wr_d = is_wr_q;  adr_cnt_d = adr_cnt_q;
    adr_hi_d = adr_hi_q; addr_d = addr_q;   off_d = off_q;
    got_d = got_q;      sr_d = sr_q;        so_d = so_q;
    set_wel = 1'b0; clr_wel = 1'b0; buf_clr = 1'b0; buf_we = 1'b0;
    commit_req = cs_rise && got_q && (bit_cnt == 3'd0) &&
                 ((phase_q == PH_WDAT) || (phase_q == PH_SDAT));
    if (cs_n) begin
      phase_d = PH_OPC;
      got_d = 1'b0;
      adr_cnt_d = 1'b0;
    end else begin
      if (fall_stb) begin
        if (phase_q == PH_RDAT)      so_d = rd_data[~bit_cnt];
        else if (phase_q == PH_STAT) so_d = status_byte[~bit_cnt];
      end
      if (byte_stb) begin
        case (phase_q)
          PH_OPC: begin
            if (wip && (byte_val != OPC_RSTAT)) begin
              phase_d = PH_SKIP;
            end else begin
              case (byte_val)
                OPC_WEN:   begin set_wel = 1'b1; phase_d = PH_SKIP; end
                OPC_WDIS:  begin clr_wel = 1'b1; phase_d = PH_SKIP; end
                OPC_RSTAT: phase_d = PH_STAT;
                OPC_WSTAT: phase_d = PH_SDAT;
                OPC_RD:    begin phase_d = PH_ADR; is_wr_d = 1'b0; end
                OPC_WR:    begin phase_d = PH_ADR; is_wr_d = 1'b1; buf_clr = 1'b1; end
                default:   phase_d = PH_SKIP;
              endcase
            end
          end
          PH_ADR: begin
            if (!adr_cnt_q) begin
              adr_hi_d  = byte_val;
              adr_cnt_d = 1'b1;
            end else begin
              addr_d  = full_addr[ADDR_W-1:0];
              off_d   = full_addr[PAGE_W-1:0];
              phase_d = is_wr_q ? PH_WDAT : PH_RDAT;
            end
          end
          PH_RDAT: addr_d = addr_q + 1'b1;
          PH_WDAT: begin buf_we = 1'b1; off_d = off_q + 1'b1; got_d = 1'b1; end
          PH_SDAT: begin sr_d = byte_val[3:2]; got_d = 1'b1; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OPC; is_wr_q <= 1'b0; adr_cnt_q <= 1'b0; got_q <= 1'b0;
      so_q <= 1'b0; adr_hi_q <= '0; addr_q <= '0; off_q <= '0; sr_q <= 2'b00;
    end else begin
      phase_q <= phase_d; is_wr_q <= is_wr_d; adr_cnt_q <= adr_cnt_d; got_q <= got_d;
      so_q <= so_d; adr_hi_q <= adr_hi_d; addr_q <= addr_d; off_q <= off_d; sr_q <= sr_d;
    end
  end

  assign so          = so_q;
  assign so_en       = !cs_n && hold_n && ((phase_q == PH_RDAT) || (phase_q == PH_STAT));
  assign rd_addr     = addr_q;
  assign buf_idx     = off_q;
  assign buf_data    = byte_val;
  assign commit_tgt  = (phase_q == PH_SDAT) ? TGT_STATUS : TGT_ARRAY;
  assign commit_addr = addr_q;
  assign commit_sr   = sr_q;
endmodule

// File: rtl/smf_status_unit.sv
module smf_status_unit import smf_pkg::*; #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     set_wel,
  input  logic                     clr_wel,
  input  logic                     commit_req,
  input  tgt_e                     commit_tgt,
  input  logic [ADDR_W-1:0]        commit_addr,
  input  logic [1:0]               commit_sr,
  output logic                     wip,
  output logic                     wel,
  output logic [BYTE_W-1:0]        status_byte,
  output logic                     eng_we,
  output logic [PAGE_W-1:0]        eng_idx,
  output logic [ADDR_W-PAGE_W-1:0] eng_base
);
  localparam int TMR_W = $clog2(WR_CYCLES);
  localparam int SLOTS = 1 << PAGE_W;

  logic                     wip_q, wip_d, wel_q, wel_d, prot, grant, unused_lo;
  logic [1:0]               bp_q, bp_d, qtr;
  logic [TMR_W-1:0]         tmr_q, tmr_d;
  tgt_e                     tgt_q, tgt_d;
  logic [ADDR_W-PAGE_W-1:0] page_q, page_d;

  assign qtr       = commit_addr[ADDR_W-1 -: 2];
  assign unused_lo = ^commit_addr[PAGE_W-1:0];

  always_comb begin
    case (bp_q)
      2'b00:   prot = 1'b0;
      2'b01:   prot = (qtr == 2'b11);
      2'b10:   prot = qtr[1];
      default: prot = 1'b1;
    endcase
  end

  assign grant = commit_req && wel_q && !wip_q && ((commit_tgt == TGT_STATUS) || !prot);

  always_comb begin
    wip_d = wip_q; wel_d = wel_q; bp_d = bp_q;
    tmr_d = tmr_q; tgt_d = tgt_q; page_d = page_q;
    if (clr_wel)      wel_d = 1'b0;
    else if (set_wel) wel_d = 1'b1;
    if (grant) begin
      wip_d  = 1'b1;
      tmr_d  = '0;
      tgt_d  = commit_tgt;
      page_d = commit_addr[ADDR_W-1:PAGE_W];
      if (commit_tgt == TGT_STATUS) bp_d = commit_sr;
    end else if (wip_q) begin
      if (tmr_q == TMR_W'(WR_CYCLES - 1)) begin
        wip_d = 1'b0;
        wel_d = 1'b0;
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip_q <= 1'b0; wel_q <= 1'b0; bp_q <= 2'b00;
      tmr_q <= '0; tgt_q <= TGT_ARRAY; page_q <= '0;
    end else begin
      wip_q <= wip_d; wel_q <= wel_d; bp_q <= bp_d;
      tmr_q <= tmr_d; tgt_q <= tgt_d; page_q <= page_d;
    end
  end

  assign wip         = wip_q;
  assign wel         = wel_q;
  assign status_byte = wip_q ? 8'hFF : {4'b0000, bp_q, wel_q, 1'b0};
  assign eng_we      = wip_q && (tgt_q == TGT_ARRAY) && (tmr_q < TMR_W'(SLOTS));
  assign eng_idx     = tmr_q[PAGE_W-1:0];
  assign eng_base    = page_q;
endmodule

// File: rtl/smf_array.sv
module smf_array import smf_pkg::*; #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     buf_clr,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_idx,
  input  logic [BYTE_W-1:0]        buf_data,
  input  logic                     eng_we,
  input  logic [PAGE_W-1:0]        eng_idx,
  input  logic [ADDR_W-PAGE_W-1:0] eng_base,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [BYTE_W-1:0]        rd_data,
  output logic                     mem_we
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << PAGE_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] slot_w [SLOTS];
  logic [SLOTS-1:0]  mask_w;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic              hit, m_q;
    logic [BYTE_W-1:0] d_q;
    assign hit = buf_we && (buf_idx == PAGE_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       m_q <= 1'b0;
      else if (buf_clr) m_q <= 1'b0;
      else if (hit)     m_q <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (hit) d_q <= buf_data;
    end
    assign mask_w[g] = m_q;
    assign slot_w[g] = d_q;
  end

  assign mem_we = eng_we && mask_w[eng_idx];

  always_ff @(posedge clk) begin
    if (mem_we) mem[{eng_base, eng_idx}] <= slot_w[eng_idx];
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/smf_spi_mem_front.sv
module smf_spi_mem_front import smf_pkg::*; #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_si,
  input  logic spi_hold_n,
  output logic spi_so,
  output logic spi_so_en
);
  logic                     rst_meta_q, rst_sync_n;
  logic                     fall_stb, cs_rise, byte_stb;
  logic [BYTE_W-1:0]        byte_val, status_byte, rd_data, buf_data;
  logic [2:0]               bit_cnt;
  logic                     wip, wel, set_wel, clr_wel, buf_clr, buf_we, commit_req, eng_we, mem_we;
  logic [ADDR_W-1:0]        rd_addr, commit_addr;
  logic [PAGE_W-1:0]        buf_idx, eng_idx;
  logic [ADDR_W-PAGE_W-1:0] eng_base;
  logic [1:0]               commit_sr;
  tgt_e                     commit_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  smf_bit_engine u_bits (
    .clk(clk), .rst_n(rst_sync_n), .cs_n(spi_cs_n), .sck(spi_sck), .si(spi_si),
    .hold_n(spi_hold_n), .fall_stb(fall_stb), .cs_rise(cs_rise), .byte_stb(byte_stb),
    .byte_val(byte_val), .bit_cnt(bit_cnt)
  );

  smf_cmd_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .cs_n(spi_cs_n), .hold_n(spi_hold_n),
    .fall_stb(fall_stb), .cs_rise(cs_rise), .byte_stb(byte_stb), .byte_val(byte_val),
    .bit_cnt(bit_cnt), .wip(wip), .status_byte(status_byte), .rd_data(rd_data),
    .so(spi_so), .so_en(spi_so_en), .rd_addr(rd_addr), .set_wel(set_wel),
    .clr_wel(clr_wel), .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_data(buf_data), .commit_req(commit_req), .commit_tgt(commit_tgt),
    .commit_addr(commit_addr), .commit_sr(commit_sr)
  );

  smf_status_unit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_stat (
    .clk(clk), .rst_n(rst_sync_n), .set_wel(set_wel), .clr_wel(clr_wel),
    .commit_req(commit_req), .commit_tgt(commit_tgt), .commit_addr(commit_addr),
    .commit_sr(commit_sr), .wip(wip), .wel(wel), .status_byte(status_byte),
    .eng_we(eng_we), .eng_idx(eng_idx), .eng_base(eng_base)
  );

  smf_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_mem (
    .clk(clk), .rst_n(rst_sync_n), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_idx(buf_idx), .buf_data(buf_data), .eng_we(eng_we), .eng_idx(eng_idx),
    .eng_base(eng_base), .rd_addr(rd_addr), .rd_data(rd_data), .mem_we(mem_we)
  );
endmodule

// File: rtl/smf_spi_mem_front_chk.sv
module smf_spi_mem_front_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_so,
  input logic wip,
  input logic wel,
  input logic mem_we
);
  AST_SO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_so) |-> !$past(spi_sck)); // R2

  AST_CYCLE_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(spi_cs_n)); // R7

  AST_ARRAY_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wip); // R7

  AST_NO_WEL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(wip)); // R8

  AST_WEL_CLR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel); // R8
endmodule

bind smf_spi_mem_front smf_spi_mem_front_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
  .spi_so(spi_so), .wip(wip), .wel(wel), .mem_we(mem_we)
);

// File: tb/tb_smf_spi_mem_front.sv
module tb_smf_spi_mem_front;
  localparam int AW   = 11;
  localparam int HALF = 4;
  localparam logic [15:0] TOP = 16'((1 << AW) - 1);

  logic clk, rst_n, cs_n, sck, si, hold_n;
  logic so, so_en;
  int   n_chk, n_fail;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       mon_on;
  logic [7:0] mon_sh;
  int         mon_n;
  logic       mon_en_ok;
  logic [7:0] tbuf[32];
  logic [7:0] st;

  smf_spi_mem_front dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
    .spi_hold_n(hold_n), .spi_so(so), .spi_so_en(so_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // monitor: collects bits on rising serial clock and pops the scoreboard
  initial begin mon_n = 0; mon_sh = 8'h00; mon_en_ok = 1'b1; end
  always @(posedge sck) begin
    if (mon_on && hold_n && !cs_n) begin
      if (!so_en) mon_en_ok = 1'b0;
      mon_sh = {mon_sh[6:0], so};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected byte", mon_sh, 8'h00);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(mon_sh == e && mon_en_ok, t, mon_sh, e);
        end
        mon_en_ok = 1'b1;
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic tx, output logic rx);
    @(negedge clk); sck = 1'b0; si = tx;
    wclk(HALF);
    rx = so; sck = 1'b1;
    wclk(HALF - 1);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
  endtask

  task automatic cs_lo();
    @(negedge clk); cs_n = 1'b0; wclk(2);
  endtask

  task automatic cs_hi();
    @(negedge clk); sck = 1'b0; wclk(2);
    cs_n = 1'b1; wclk(4);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_lo(); spi_byte(op, r); cs_hi();
  endtask

  task automatic get_status(output logic [7:0] s);
    logic [7:0] r;
    cs_lo(); spi_byte(8'h05, r); spi_byte(8'h00, s); cs_hi();
  endtask

  task automatic wait_idle(output logic [7:0] s);
    for (int k = 0; k < 100; k++) begin
      get_status(s);
      if (!s[0]) break;
    end
    check(!s[0], "R8 busy never cleared", s, 8'h00);
  endtask

  task automatic wr_n(input logic [15:0] a, input int n);
    logic [7:0] r;
    cs_lo(); spi_byte(8'h02, r); spi_byte(a[15:8], r); spi_byte(a[7:0], r);
    for (int k = 0; k < n; k++) spi_byte(tbuf[k], r);
    cs_hi();
  endtask

  // driver: pushes expected bytes into the scoreboard, then clocks them out
  task automatic rd_n(input logic [15:0] a, input int n, input string tag);
    logic [7:0] r;
    cs_lo(); spi_byte(8'h03, r); spi_byte(a[15:8], r); spi_byte(a[7:0], r);
    for (int k = 0; k < n; k++) begin exp_q.push_back(tbuf[k]); tag_q.push_back(tag); end
    mon_on = 1'b1;
    for (int k = 0; k < n; k++) spi_byte(8'h00, r);
    mon_on = 1'b0;
    cs_hi();
    check(exp_q.size() == 0, {tag, " bytes missing"}, 8'(exp_q.size()), 8'h00);
    exp_q.delete(); tag_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    n_chk = 0; n_fail = 0; mon_on = 1'b0;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1;
    wclk(5); rst_n = 1'b1; wclk(5);

    // R12: reset state
    check(so_en == 1'b0, "R12 so_en after reset", {7'b0, so_en}, 8'h00);
    get_status(st); check(st == 8'h00, "R12 status after reset", st, 8'h00);

    // R3: set / clear write enable
    cmd1(8'h06); get_status(st); check(st == 8'h02, "R3 set enable", st, 8'h02);
    cmd1(8'h04); get_status(st); check(st == 8'h00, "R3 clear enable", st, 8'h00);

    // R1: unknown opcode ignored, output stays disabled
    cmd1(8'h06);
    cs_lo(); spi_byte(8'h0F, r); spi_byte(8'hAA, r);
    check(so_en == 1'b0, "R1 so_en on unknown opcode", {7'b0, so_en}, 8'h00);
    cs_hi();
    get_status(st); check(st == 8'h02, "R1 unknown opcode no effect", st, 8'h02);

    // R7/R4/R8: committed write, status during busy, opcode ignored while busy
    tbuf[0] = 8'hA0; tbuf[1] = 8'hA1; tbuf[2] = 8'hA2; tbuf[3] = 8'hA3;
    wr_n(16'h0010, 4);
    get_status(st); check(st == 8'hFF, "R4 status while busy", st, 8'hFF);
    cmd1(8'h06);
    wait_idle(st); check(st == 8'h00, "R8 enable cleared, set ignored when busy", st, 8'h00);

    // R5/R2: sequential read
    rd_n(16'h0010, 4, "R5 sequential read");

    // R7: write without enable discarded
    tbuf[0] = 8'h55; wr_n(16'h0010, 1);
    get_status(st); check(st == 8'h00, "R7 no cycle without enable", st, 8'h00);
    tbuf[0] = 8'hA0; rd_n(16'h0010, 1, "R7 data kept without enable");

    // R7: partial byte and zero data bytes discarded
    cmd1(8'h06);
    cs_lo(); spi_byte(8'h02, r); spi_byte(8'h00, r); spi_byte(8'h10, r);
    spi_byte(8'h77, r); spi_bit(1'b1, r); spi_bit(1'b0, r); spi_bit(1'b1, r); cs_hi();
    get_status(st); check(st == 8'h02, "R7 partial byte no cycle", st, 8'h02);
    wr_n(16'h0010, 0);
    get_status(st); check(st == 8'h02, "R7 no data byte no cycle", st, 8'h02);
    tbuf[0] = 8'hA0; rd_n(16'h0010, 1, "R7 partial write discarded");
    cmd1(8'h04);

    // R6: page wrap on write
    cmd1(8'h06);
    tbuf[0] = 8'h11; tbuf[1] = 8'h22; tbuf[2] = 8'h33; tbuf[3] = 8'h44;
    wr_n(16'h003E, 4); wait_idle(st);
    tbuf[0] = 8'h11; tbuf[1] = 8'h22; rd_n(16'h003E, 2, "R6 page end bytes");
    tbuf[0] = 8'h33; tbuf[1] = 8'h44; rd_n(16'h0020, 2, "R6 wrapped to page start");

    // R5: read address wraps at top of array
    cmd1(8'h06); tbuf[0] = 8'h5A; wr_n(16'h0000, 1); wait_idle(st);
    cmd1(8'h06); tbuf[0] = 8'hC3; wr_n(TOP, 1); wait_idle(st);
    tbuf[0] = 8'hC3; tbuf[1] = 8'h5A; rd_n(TOP, 2, "R5 address wrap");

    // R9: pause mid-byte while the clock keeps toggling
    cs_lo(); spi_byte(8'h03, r); spi_byte(8'h00, r); spi_byte(8'h10, r);
    exp_q.push_back(8'hA0); tag_q.push_back("R9 byte across pause");
    exp_q.push_back(8'hA1); tag_q.push_back("R9 stream after pause");
    mon_on = 1'b1;
    for (int k = 0; k < 3; k++) spi_bit(1'b0, r);
    @(negedge clk); hold_n = 1'b0; wclk(2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); sck = 1'b0; wclk(HALF); sck = 1'b1; wclk(HALF);
    end
    check(so_en == 1'b0, "R9 so_en low in pause", {7'b0, so_en}, 8'h00);
    @(negedge clk); hold_n = 1'b1; wclk(2);
    for (int k = 0; k < 13; k++) spi_bit(1'b0, r);
    mon_on = 1'b0; cs_hi();
    check(exp_q.size() == 0, "R9 bytes missing", 8'(exp_q.size()), 8'h00);
    exp_q.delete(); tag_q.delete();

    // R11: status write sets protect bits
    cmd1(8'h06);
    cs_lo(); spi_byte(8'h01, r); spi_byte(8'h04, r); cs_hi();
    wait_idle(st); check(st == 8'h04, "R11 protect top quarter stored", st, 8'h04);

    // R10: top quarter blocked, lower area writable
    cmd1(8'h06); tbuf[0] = 8'h99; wr_n(TOP, 1);
    get_status(st); check(st == 8'h06, "R10 blocked write keeps enable", st, 8'h06);
    tbuf[0] = 8'hC3; rd_n(TOP, 1, "R10 top quarter unchanged");
    tbuf[0] = 8'h66; wr_n(16'h0020, 1); wait_idle(st);
    check(st == 8'h04, "R10 unprotected write done", st, 8'h04);
    tbuf[0] = 8'h66; rd_n(16'h0020, 1, "R10 unprotected data");

    // R10: whole array protected
    cmd1(8'h06);
    cs_lo(); spi_byte(8'h01, r); spi_byte(8'h0C, r); cs_hi();
    wait_idle(st); check(st == 8'h0C, "R11 protect all stored", st, 8'h0C);
    cmd1(8'h06); tbuf[0] = 8'h99; wr_n(16'h0010, 1);
    get_status(st); check(st == 8'h0E, "R10 all blocked", st, 8'h0E);
    tbuf[0] = 8'hA0; rd_n(16'h0010, 1, "R10 data unchanged");

    // R11: status write without enable discarded
    cmd1(8'h04);
    cs_lo(); spi_byte(8'h01, r); spi_byte(8'h00, r); cs_hi();
    get_status(st); check(st == 8'h0C, "R11 status write without enable", st, 8'h0C);

    finish_run();
  end
endmodule